// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is a synchronous Moore controller for a candy dispenser. It accepts two kinds of coin: a 5-cent piece and a 10-cent piece. Each coin mechanism drives a raw sense level, and that level may stay high for several clock cycles. A two-stage front end turns each rising level into a coin pulse that lasts exactly one clock cycle. The credit machine adds up the value of the coins. When the credit reaches 15 cents it raises a one-cycle `vend` strobe. Change is never given back. If the credit reaches 20 cents, the extra 5 cents stays as credit toward the next candy.

The machine has five states:

| State | Meaning | `vend` |
|---|---|---|
| `ST_ZERO` | no credit | 0 |
| `ST_FIVE` | 5 cents of credit | 0 |
| `ST_TEN` | 10 cents of credit | 0 |
| `ST_VEND15` | dispensing after exactly 15 cents | 1 |
| `ST_VEND20` | dispensing after 20 cents | 1 |

The transitions are:

- **Hold:** in `ST_ZERO`, `ST_FIVE` or `ST_TEN`, the state does not change while no coin pulse is present.
- **Nickel:** `ST_ZERO` goes to `ST_FIVE`, `ST_FIVE` goes to `ST_TEN`, and `ST_TEN` goes to `ST_VEND15`.
- **Dime:** `ST_ZERO` goes to `ST_TEN`, `ST_FIVE` goes to `ST_VEND15`, and `ST_TEN` goes to `ST_VEND20`.
- **Vend exit:** `ST_VEND15` always goes to `ST_ZERO`, and `ST_VEND20` always goes to `ST_FIVE`.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` (active high, synchronous) is sampled high, the next state is `ST_ZERO`, both shaper stages of both coin lines are cleared, and `vend` is 0 in the following cycle.
- R2: Each raw sense assertion produces exactly one coin pulse, one cycle long, however many cycles the raw level stays high (1 cycle or more).
- R3: A nickel pulse moves zero credit to 5 cents, 5 cents to 10 cents, and 10 cents to `ST_VEND15`.
- R4: A dime pulse moves zero credit to 10 cents, 5 cents to `ST_VEND15`, and 10 cents to `ST_VEND20`.
- R5: After `ST_VEND15` the credit is zero. A 15-cent total gives one vend and leaves no credit.
- R6: After `ST_VEND20` the credit is 5 cents. A 20-cent total gives one vend, and 10 more cents then complete the next purchase.
- R7: `vend` is high for exactly one cycle per purchase. If a raw level is first sampled high at clock edge k, `vend` is high during the cycle after edge k+1.
- R8: A coin pulse that arrives while a vend state is active is ignored. The exit from a vend state depends only on which vend state it is.
- R9: In a credit state with no coin pulse, the credit is held for any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nickel_sense | input | 1 | Raw 5-cent coin sense level |
| dime_sense | input | 1 | Raw 10-cent coin sense level |
| vend | output | 1 | One-cycle dispense strobe |

## Verification
The assertions assume the following about the inputs:

- The two coin pulses are never high in the same cycle.
- Each raw sense level goes low at least once between coins.
- The raw levels are already synchronous to `clk`.

The stimulus keeps within these limits. It raises only one sense line at a time, and it holds each line for 1 to 3 cycles followed by a long low gap. In the one case where two lines pulse on neighbouring cycles (the ignored coin during a vend), the pulses still fall in different cycles. The raw lines are kept low while reset is applied.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int COIN_LINES = 2;
    localparam int LINE_NICKEL = 0;
    localparam int LINE_DIME   = 1;

    typedef enum logic [2:0] {
        ST_ZERO   = 3'd0,
        ST_FIVE   = 3'd1,
        ST_TEN    = 3'd2,
        ST_VEND15 = 3'd3,
        ST_VEND20 = 3'd4
    } credit_state_t;

    function automatic logic is_vend_state(input credit_state_t s);
        return (s == ST_VEND15) || (s == ST_VEND20);
    endfunction
endpackage

// File: rtl/coin_pulse_shaper.sv
module coin_pulse_shaper (
    input  logic clk,
    input  logic rst,
    input  logic sense_raw,
    output logic coin_pulse
);
    logic stage_a;
    logic stage_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a <= 1'b0;
            stage_b <= 1'b0;
        end else begin
            stage_a <= sense_raw;
            stage_b <= stage_a;
        end
    end

    assign coin_pulse = stage_a & ~stage_b;

    // R2: a coin pulse never lasts longer than one cycle
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (rst)
        coin_pulse |=> !coin_pulse);

    // R1: reset clears the shaper, so no pulse follows it
    a_r1_shaper_clear: assert property (@(posedge clk)
        rst |=> !coin_pulse);
endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_pulse,
    input  logic dime_pulse,
    output logic vend
);
    credit_state_t state_q;
    credit_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ZERO;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ZERO: begin
                if (nickel_pulse)    state_d = ST_FIVE;
                else if (dime_pulse) state_d = ST_TEN;
            end
            ST_FIVE: begin
                if (nickel_pulse)    state_d = ST_TEN;
                else if (dime_pulse) state_d = ST_VEND15;
            end
            ST_TEN: begin
                if (nickel_pulse)    state_d = ST_VEND15;
                else if (dime_pulse) state_d = ST_VEND20;
            end
            ST_VEND15: state_d = ST_ZERO;
            ST_VEND20: state_d = ST_FIVE;
            default:   state_d = ST_ZERO;
        endcase
    end

    always_comb begin
        vend = 1'b0;
        unique case (state_q)
            ST_VEND15, ST_VEND20: vend = 1'b1;
            default:              vend = 1'b0;
        endcase
    end

    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (state_q == ST_ZERO) && !vend);
    // R3
    a_r3_nickel_from_ten: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TEN && nickel_pulse && !dime_pulse) |=> state_q == ST_VEND15);
    // R4
    a_r4_dime_from_ten: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TEN && dime_pulse && !nickel_pulse) |=> state_q == ST_VEND20);
    // R5 / R8
    a_r5_exit15: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VEND15) |=> state_q == ST_ZERO);
    // R6 / R8
    a_r6_exit20: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VEND20) |=> state_q == ST_FIVE);
    // R7
    a_r7_vend_one_cycle: assert property (@(posedge clk) disable iff (rst)
        vend |=> !vend);
    // R9
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!is_vend_state(state_q) && !nickel_pulse && !dime_pulse) |=> $stable(state_q));
    a_r3_coins_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(nickel_pulse && dime_pulse));
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_sense,
    input  logic dime_sense,
    output logic vend
);
    logic [COIN_LINES-1:0] sense_raw;
    logic [COIN_LINES-1:0] coin_pulse;

    assign sense_raw[LINE_NICKEL] = nickel_sense;
    assign sense_raw[LINE_DIME]   = dime_sense;

    for (genvar g = 0; g < COIN_LINES; g++) begin : g_shaper
        coin_pulse_shaper u_shaper (
            .clk        (clk),
            .rst        (rst),
            .sense_raw  (sense_raw[g]),
            .coin_pulse (coin_pulse[g])
        );
    end

    vend_credit_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .nickel_pulse (coin_pulse[LINE_NICKEL]),
        .dime_pulse   (coin_pulse[LINE_DIME]),
        .vend         (vend)
    );
endmodule

// File: tb/vend_ctrl_test.sv
module vend_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_sense = 1'b0;
    logic dime_sense = 1'b0;
    logic vend;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vend_ctrl uut (
        .clk(clk), .rst(rst),
        .nickel_sense(nickel_sense), .dime_sense(dime_sense),
        .vend(vend)
    );

    // entry: {coin[1:0] (1=nickel, 2=dime), hold cycles[1:0], expected vend count}
    localparam int NVEC = 14;
    localparam logic [4:0] VEC [0:NVEC-1] = '{
        {2'd1, 2'd3, 1'b0},  // 0  -> 5   R3
        {2'd1, 2'd1, 1'b0},  // 5  -> 10  R3, R2 single cycle
        {2'd1, 2'd3, 1'b1},  // 10 -> 15 vend -> 0  R3 R5
        {2'd2, 2'd3, 1'b0},  // 0  -> 10  R4
        {2'd2, 2'd2, 1'b1},  // 10 -> 20 vend -> 5  R4 R6
        {2'd2, 2'd3, 1'b1},  // 5  -> 15 vend -> 0  R4 R6
        {2'd1, 2'd2, 1'b0},  // 0  -> 5
        {2'd2, 2'd1, 1'b1},  // 5  -> 15 vend -> 0
        {2'd2, 2'd3, 1'b0},  // 0  -> 10
        {2'd1, 2'd3, 1'b1},  // 10 -> 15 vend -> 0
        {2'd2, 2'd3, 1'b0},  // 0  -> 10
        {2'd2, 2'd1, 1'b1},  // 10 -> 20 vend -> 5
        {2'd1, 2'd3, 1'b0},  // 5  -> 10
        {2'd1, 2'd3, 1'b1}   // 10 -> 15 vend -> 0
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // raise a line before edge 1, clear it after edge 'hold'; samples taken after edges 1..8
    task automatic run_coin(input logic [1:0] c, input int hold, output int cnt, output int first);
        @(negedge clk);
        nickel_sense = (c == 2'd1);
        dime_sense   = (c == 2'd2);
        cnt = 0;
        first = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == hold) begin
                nickel_sense = 1'b0;
                dime_sense = 1'b0;
            end
            if (vend) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic coin_expect(input logic [1:0] c, input int hold, input int exp, input string tag);
        int cnt, first;
        run_coin(c, hold, cnt, first);
        check(cnt == exp, tag, cnt, exp);
        if (exp == 1) check(first == 2, {tag, " R7 timing"}, first, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt, first;
        repeat (3) @(negedge clk);
        check(vend == 1'b0, "R1 vend low in reset", vend, 0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            run_coin(VEC[v][4:3], int'(VEC[v][2:1]), cnt, first);
            check(cnt == int'(VEC[v][0]), $sformatf("R2/R3/R4 vector %0d vend count", v), cnt, VEC[v][0]);
            if (VEC[v][0]) check(first == 2, $sformatf("R7 vector %0d vend cycle", v), first, 2);
        end

        // R9: long idle keeps credit: 10 cents, idle, then nickel vends
        coin_expect(2'd2, 2, 0, "R9 load ten");
        repeat (50) @(negedge clk);
        check(vend == 1'b0, "R9 idle no vend", vend, 0);
        coin_expect(2'd1, 3, 1, "R9 credit held after idle");

        // R8: dime pulse during VEND15 ignored
        coin_expect(2'd2, 3, 0, "R8 load ten");
        @(negedge clk);
        nickel_sense = 1'b1;           // sampled at e1, pulse e1-e2, VEND15 after e2
        @(negedge clk);
        nickel_sense = 1'b0;
        dime_sense = 1'b1;             // sampled at e2, pulse during VEND15
        @(negedge clk);
        check(vend == 1'b1, "R8 vend while dime pulses", vend, 1);
        dime_sense = 1'b0;
        repeat (4) @(negedge clk);
        coin_expect(2'd1, 3, 0, "R8 credit zero after ignored dime (5)");
        coin_expect(2'd1, 3, 0, "R8 credit zero after ignored dime (10)");
        coin_expect(2'd1, 3, 1, "R8 third nickel vends");

        // R1: reset from 10 cents clears credit
        coin_expect(2'd2, 3, 0, "R1 load ten");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(vend == 1'b0, "R1 vend low during reset", vend, 0);
        rst = 1'b0;
        coin_expect(2'd1, 3, 0, "R1 credit cleared (5)");
        coin_expect(2'd1, 3, 0, "R1 credit cleared (10)");
        coin_expect(2'd1, 3, 1, "R1 fresh purchase vends");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule